// File: doc/BRIEF.md
# Block Erase Queue and Sequencer

This block sits behind the command decoder of a flash memory controller. It gathers the set of blocks that one erase operation will clear, holds an acceptance window open while more block selections may arrive, and then walks through the selected blocks one at a time. Blocks whose protect bit is set are skipped. A modeled array does the erasing and reports when each block is finished.

The first selection pulse moves the block out of idle and opens the window. Each later selection inside the window adds its block to a one-bit-per-block list and restarts the window timer. When the window closes, the list is frozen. Erasure then runs in ascending block index. The caller can suspend and resume the operation. A suspend during the window takes effect at once. A suspend during erasure takes effect only after a fixed latency.

If every listed block is protected, the block stays busy for a short fixed time and then finishes. No erase is requested. All durations are parameters given in clock cycles.

Top module: `blk_erase_seq`

## Requirements
- R1: After reset, `busy`, `win_open`, `erase_act`, `suspended` and `done` are all 0.
- R2: When `sel_vld` is sampled high in idle, `win_open` goes high on the next cycle. If no further selection arrives, `win_open` stays high for exactly WIN_CYC cycles, and erasure or the protected-only run begins in the cycle after that.
- R3: A selection sampled while `win_open` is high adds its block and restarts the WIN_CYC count from that cycle.
- R4: During erasure, `erase_act` is high and `cur_idx` names one block. That block stays current until `blk_done` is sampled high. Blocks are erased in ascending index order, and the next block is presented in the cycle right after the completion.
- R5: A block whose `prot` bit is 1 when the window closes or the run resumes is never presented on `cur_idx` with `erase_act` high. Skipping it raises no error.
- R6: If every listed block is protected, `busy` stays high and `erase_act` stays low for exactly FAKE_CYC cycles after the window closes. Then `done` pulses and `busy` falls.
- R7: A `susp_req` sampled while the window is open clears `win_open` and sets `suspended` on the next cycle. A later `resume_req` starts erasure on the following cycle.
- R8: A `susp_req` sampled during erasure keeps `erase_act` high for exactly SLAT_CYC more cycles. Then `erase_act` falls and `suspended` rises.
- R9: Selections sampled after the window has closed are ignored. This holds while erasing, while suspended and after a resume.
- R10: `done` is a single-cycle pulse in the cycle where `busy` first reads 0 after the last listed block completes.
- R11: Selecting the same block more than once erases it only once.
- R12: Suspend and resume may be repeated any number of times within one operation. Each resume continues with the block that was current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_vld | input | 1 | Block selection pulse |
| sel_idx | input | $clog2(NBLK) | Index of the selected block |
| prot | input | NBLK | Protect bit for each block |
| susp_req | input | 1 | Suspend request pulse |
| resume_req | input | 1 | Resume request pulse |
| blk_done | input | 1 | Array reports that the current block is erased |
| busy | output | 1 | An operation is in progress |
| win_open | output | 1 | Acceptance window is open |
| erase_act | output | 1 | Array must erase the block on cur_idx |
| cur_idx | output | $clog2(NBLK) | Block being erased |
| suspended | output | 1 | Operation is suspended |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume three things about the inputs. First, `prot` stays stable from the first selection until `done`. Second, `blk_done` is only raised while `erase_act` is high. Third, `sel_idx` is always below NBLK.

The bench meets these assumptions by construction. It changes `prot` only while the block is idle. Its array model pulses `blk_done` only after seeing `erase_act` with the expected index. It draws random indices only inside the block count.

Stray selections and suspend or resume pulses are injected only at points where the requirements say they must be ignored.

// File: rtl/eq_pkg.sv
package eq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WIN   = 3'd1,
    ST_ERASE = 3'd2,
    ST_SPEND = 3'd3,
    ST_SUSP  = 3'd4,
    ST_FAKE  = 3'd5
  } eq_state_e;
endpackage

// File: rtl/eq_downcnt.sv
module eq_downcnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                     cnt_d = load_val;
    else if (dec && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load | dec) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/eq_lowpick.sv
module eq_lowpick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/eq_blk_list.sv
module eq_blk_list #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_en,
  input  logic [IW-1:0] add_idx,
  input  logic          rm_en,
  input  logic [IW-1:0] rm_idx,
  input  logic          clr_all,
  output logic [N-1:0]  list
);
  logic [N-1:0] list_q, list_d, add_mask, rm_mask;

  generate
    for (genvar g = 0; g < N; g++) begin : g_mask
      assign add_mask[g] = add_en && (add_idx == IW'(g));
      assign rm_mask[g]  = rm_en  && (rm_idx  == IW'(g));
    end
  endgenerate

  always_comb begin
    if (clr_all) list_d = '0;
    else         list_d = (list_q | add_mask) & ~rm_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       list_q <= '0;
    else if (add_en | rm_en | clr_all) list_q <= list_d;
  end

  assign list = list_q;
endmodule

// File: rtl/blk_erase_seq.sv
module blk_erase_seq #(
  parameter int NBLK     = 8,
  parameter int WIN_CYC  = 16,
  parameter int FAKE_CYC = 8,
  parameter int SLAT_CYC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_vld,
  input  logic [$clog2(NBLK)-1:0] sel_idx,
  input  logic [NBLK-1:0]         prot,
  input  logic                    susp_req,
  input  logic                    resume_req,
  input  logic                    blk_done,
  output logic                    busy,
  output logic                    win_open,
  output logic                    erase_act,
  output logic [$clog2(NBLK)-1:0] cur_idx,
  output logic                    suspended,
  output logic                    done
);
  import eq_pkg::*;

  localparam int IW   = $clog2(NBLK);
  localparam int MX1  = (WIN_CYC > FAKE_CYC) ? WIN_CYC : FAKE_CYC;
  localparam int MAXC = (MX1 > SLAT_CYC) ? MX1 : SLAT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  eq_state_e    st_q, st_d;
  logic [IW-1:0] cur_q, cur_d;
  logic          done_q, done_d;
  logic          cnt_ld, cnt_dec, cnt_zero;
  logic [CW-1:0] cnt_ldv;
  logic          add_en, rm_en, clr_all;
  logic [NBLK-1:0] list_q, done_mask, pick_vec;
  logic          pick_found;
  logic [IW-1:0] pick_idx;
  logic          in_erase, done_acc;

  assign in_erase = (st_q == ST_ERASE) || (st_q == ST_SPEND);
  assign done_acc = in_erase && blk_done;

  generate
    for (genvar g = 0; g < NBLK; g++) begin : g_dmask
      assign done_mask[g] = done_acc && (cur_q == IW'(g));
    end
  endgenerate

  assign pick_vec = list_q & ~prot & ~done_mask;

  eq_blk_list #(.N(NBLK), .IW(IW)) u_list (
    .clk(clk), .rst_n(rst_n),
    .add_en(add_en), .add_idx(sel_idx),
    .rm_en(rm_en), .rm_idx(cur_q),
    .clr_all(clr_all), .list(list_q)
  );

  eq_lowpick #(.N(NBLK), .IW(IW)) u_pick (
    .vec(pick_vec), .found(pick_found), .idx(pick_idx)
  );

  eq_downcnt #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(cnt_ld), .load_val(cnt_ldv), .dec(cnt_dec), .zero(cnt_zero)
  );

  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    done_d  = 1'b0;
    cnt_ld  = 1'b0;
    cnt_ldv = '0;
    cnt_dec = 1'b0;
    add_en  = 1'b0;
    rm_en   = 1'b0;
    clr_all = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (sel_vld) begin
          add_en  = 1'b1;
          cnt_ld  = 1'b1;
          cnt_ldv = CW'(WIN_CYC - 1);
          st_d    = ST_WIN;
        end
      end
      ST_WIN: begin
        if (susp_req) begin
          st_d = ST_SUSP;
        end else if (sel_vld) begin
          add_en  = 1'b1;
          cnt_ld  = 1'b1;
          cnt_ldv = CW'(WIN_CYC - 1);
        end else if (cnt_zero) begin
          if (pick_found) begin
            st_d  = ST_ERASE;
            cur_d = pick_idx;
          end else begin
            st_d    = ST_FAKE;
            cnt_ld  = 1'b1;
            cnt_ldv = CW'(FAKE_CYC - 1);
          end
        end else begin
          cnt_dec = 1'b1;
        end
      end
      ST_ERASE: begin
        if (blk_done) begin
          rm_en = 1'b1;
          if (pick_found) begin
            cur_d = pick_idx;
            if (susp_req) begin
              st_d    = ST_SPEND;
              cnt_ld  = 1'b1;
              cnt_ldv = CW'(SLAT_CYC - 1);
            end
          end else begin
            st_d    = ST_IDLE;
            clr_all = 1'b1;
            done_d  = 1'b1;
          end
        end else if (susp_req) begin
          st_d    = ST_SPEND;
          cnt_ld  = 1'b1;
          cnt_ldv = CW'(SLAT_CYC - 1);
        end
      end
      ST_SPEND: begin
        if (blk_done && !pick_found) begin
          rm_en   = 1'b1;
          st_d    = ST_IDLE;
          clr_all = 1'b1;
          done_d  = 1'b1;
        end else begin
          if (blk_done) begin
            rm_en = 1'b1;
            cur_d = pick_idx;
          end
          if (cnt_zero) st_d = ST_SUSP;
          else          cnt_dec = 1'b1;
        end
      end
      ST_SUSP: begin
        if (resume_req) begin
          if (pick_found) begin
            st_d  = ST_ERASE;
            cur_d = pick_idx;
          end else begin
            st_d    = ST_FAKE;
            cnt_ld  = 1'b1;
            cnt_ldv = CW'(FAKE_CYC - 1);
          end
        end
      end
      ST_FAKE: begin
        if (cnt_zero) begin
          st_d    = ST_IDLE;
          clr_all = 1'b1;
          done_d  = 1'b1;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      done_q <= done_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign win_open  = (st_q == ST_WIN);
  assign erase_act = in_erase;
  assign suspended = (st_q == ST_SUSP);
  assign cur_idx   = cur_q;
  assign done      = done_q;
endmodule

// File: rtl/eq_chk.sv
module eq_chk #(
  parameter int NBLK = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sel_vld,
  input logic [NBLK-1:0]         prot,
  input logic                    resume_req,
  input logic                    blk_done,
  input logic                    busy,
  input logic                    win_open,
  input logic                    erase_act,
  input logic [$clog2(NBLK)-1:0] cur_idx,
  input logic                    suspended,
  input logic                    done
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!win_open && !erase_act && !suspended)); // R1

  AST_WIN_FROM_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(sel_vld)); // R2

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({win_open, erase_act, suspended})); // R7

  AST_CUR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_act && !blk_done) |=> $stable(cur_idx)); // R4

  AST_NO_PROT_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_act |-> !prot[cur_idx]); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

  AST_SUSP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !resume_req) |=> suspended); // R12
endmodule

bind blk_erase_seq eq_chk #(.NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_vld(sel_vld), .prot(prot),
  .resume_req(resume_req), .blk_done(blk_done), .busy(busy),
  .win_open(win_open), .erase_act(erase_act), .cur_idx(cur_idx),
  .suspended(suspended), .done(done)
);

// File: tb/sim_blk_erase_seq.sv
module sim_blk_erase_seq;
  localparam int CLK_PER = 10;
  localparam int N    = 8;
  localparam int IW   = $clog2(N);
  localparam int WIN  = 16;
  localparam int FAKE = 8;
  localparam int SLAT = 4;

  logic clk = 1'b0;
  logic rst_n, sel_vld, susp_req, resume_req, blk_done;
  logic [IW-1:0] sel_idx, cur_idx;
  logic [N-1:0] prot;
  logic busy, win_open, erase_act, suspended, done;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit ended = 0;

  always #(CLK_PER/2) clk = ~clk;

  blk_erase_seq #(.NBLK(N), .WIN_CYC(WIN), .FAKE_CYC(FAKE), .SLAT_CYC(SLAT)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_vld(sel_vld), .sel_idx(sel_idx), .prot(prot),
    .susp_req(susp_req), .resume_req(resume_req), .blk_done(blk_done),
    .busy(busy), .win_open(win_open), .erase_act(erase_act), .cur_idx(cur_idx),
    .suspended(suspended), .done(done)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic finish_report();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // window phase: win_open for WIN samples from the last selection
  task automatic check_window(input string tag);
    for (int k = 0; k < WIN; k++) begin
      chk(win_open == 1'b1, tag, win_open, 1);
      step();
    end
    chk(win_open == 1'b0, tag, win_open, 0);
  endtask

  // erasure phase: expects rem erased in ascending order; stray selects optional
  task automatic finish_erase(input logic [N-1:0] rem, input bit stray);
    logic [N-1:0] r = rem;
    while (r != '0) begin
      int e = lowest(r);
      chk(erase_act && cur_idx == IW'(e), "R4 order", int'(cur_idx), e);
      for (int d = 0; d < 1 + int'($urandom % 4); d++) begin
        if (stray) begin sel_vld = 1'b1; sel_idx = IW'(N - 1); end
        step();
        sel_vld = 1'b0;
        chk(erase_act && cur_idx == IW'(e), "R4 hold", int'(cur_idx), e);
      end
      blk_done = 1'b1;
      step();
      blk_done = 1'b0;
      r[e] = 1'b0;
    end
    chk(done == 1'b1 && busy == 1'b0, "R10 done", {busy, done}, 1);
    step();
    chk(done == 1'b0, "R10 pulse", done, 0);
  endtask

  task automatic run_op(input logic [N-1:0] sel, input logic [N-1:0] pr);
    prot = pr;
    for (int i = N - 1; i >= 0; i--) begin
      if (sel[i]) begin sel_vld = 1'b1; sel_idx = IW'(i); step(); end
    end
    sel_vld = 1'b1; sel_idx = IW'(lowest(sel)); step(); // R11 duplicate
    sel_vld = 1'b0;
    check_window("R2 window");
    if ((sel & ~pr) == '0) begin
      for (int k = 0; k < FAKE; k++) begin
        chk(busy && !erase_act, "R6 fake busy", {busy, erase_act}, 2);
        step();
      end
      chk(done && !busy, "R6 fake end", {busy, done}, 1);
      step();
    end else begin
      finish_erase(sel & ~pr, 1'b0); // R5 protected skipped
    end
  endtask

  initial begin
    while (!ended) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        finish_report();
      end
    end
  end

  initial begin
    logic [N-1:0] s, p;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; sel_vld = 1'b0; sel_idx = '0; prot = '0;
    susp_req = 1'b0; resume_req = 1'b0; blk_done = 1'b0;
    #(CLK_PER * 3);
    #1;
    chk(!busy && !win_open && !erase_act && !suspended && !done, "R1 reset",
        {busy, win_open, erase_act, suspended, done}, 0);
    @(negedge clk); rst_n = 1'b1;
    step();
    chk(!busy, "R1 after release", busy, 0);

    // R3 window restart
    prot = '0;
    sel_vld = 1'b1; sel_idx = 3'd3; step(); sel_vld = 1'b0;
    for (int k = 0; k < 5; k++) begin
      chk(win_open, "R3 open", win_open, 1); step();
    end
    sel_vld = 1'b1; sel_idx = 3'd1; step(); sel_vld = 1'b0;
    check_window("R3 restart");
    finish_erase(8'b0000_1010, 1'b1); // R9 stray selects during erase

    // R7 suspend during window
    sel_vld = 1'b1; sel_idx = 3'd2; step(); sel_vld = 1'b0;
    step(); step();
    susp_req = 1'b1; step(); susp_req = 1'b0;
    chk(suspended && !win_open && busy && !erase_act, "R7 immediate",
        {suspended, win_open, busy, erase_act}, 4'b1010);
    sel_vld = 1'b1; sel_idx = 3'd5; step(); sel_vld = 1'b0; // R9
    for (int k = 0; k < 5; k++) step();
    chk(suspended, "R7 stays", suspended, 1);
    resume_req = 1'b1; step(); resume_req = 1'b0;
    chk(erase_act && !suspended && cur_idx == 3'd2, "R7 resume", int'(cur_idx), 2);
    sel_vld = 1'b1; sel_idx = 3'd6; step(); sel_vld = 1'b0; // R9 after resume
    finish_erase(8'b0000_0100, 1'b0);

    // R8 / R12 suspend during erase, repeated
    sel_vld = 1'b1; sel_idx = 3'd4; step();
    sel_idx = 3'd0; step(); sel_vld = 1'b0;
    check_window("R2 window");
    for (int rep = 0; rep < 2; rep++) begin
      chk(erase_act && cur_idx == 3'd0, "R12 current", int'(cur_idx), 0);
      susp_req = 1'b1; step(); susp_req = 1'b0;
      for (int k = 0; k < SLAT; k++) begin
        chk(erase_act && !suspended, "R8 latency", {erase_act, suspended}, 2);
        step();
      end
      chk(suspended && !erase_act, "R8 suspended", {suspended, erase_act}, 2);
      step();
      resume_req = 1'b1; step(); resume_req = 1'b0;
      chk(erase_act && cur_idx == 3'd0, "R12 resume", int'(cur_idx), 0);
    end
    finish_erase(8'b0001_0001, 1'b0);

    // R6 all protected
    run_op(8'b0110_0000, 8'b1110_0000);

    // random mix, R5 R11
    for (int t = 0; t < 20; t++) begin
      s = N'($urandom);
      if (s == '0) s = 8'b0000_0001;
      p = N'($urandom) & N'($urandom);
      run_op(s, p);
    end
    finish_report();
  end
endmodule